// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block guards a brushless motor drive against a rotor that cannot turn. While the drive is commanded to run and the speed loop reports that the motor is outside its lock window, a digital timer counts prescaled ticks. If lock is not reached before a programmed number of ticks, a fault latches and forces the high-side drivers off. The fault persists through any change in the lock indication. It is released only by a stop command held without a break for a parameterized number of clock cycles (sized to about 1 ms), or by a fresh power-on reset.

The same block stretches the incoming power-on reset into a logic reset for the rest of the control path. The high-side drivers are held off for as long as that logic reset is active. Every timing element is a counter, so the timeout and hold times come from parameters and from one limit input rather than from external capacitors.

Top module: `rotor_stall_guard`

## Requirements
- R1: `logic_rst` is 1 while `rst` is 1 and for exactly `POR_CYC` rising clock edges after `rst` returns to 0, then stays 0 until `rst` is asserted again.
- R2: `hs_off` is 1 in every cycle in which `logic_rst` is 1.
- R3: Starting from a cleared timer with no fault, if `run_cmd`=1 and `in_lock`=0 are held, `hs_off` rises at exactly the `L*PRESCALE`-th rising edge, where L is `stall_limit` (a limit of 0 behaves as 1), and is 0 before it.
- R4: Any cycle with `in_lock`=1 (motor inside its lock window) while running returns the timer to zero, so the full `L*PRESCALE` edges are needed again after lock is lost.
- R5: Any cycle with `run_cmd`=0 (stop command) returns the timer to zero, even when that stop is too short to matter for the fault.
- R6: Once latched, the fault keeps `hs_off` at 1 whatever `in_lock` does, and a stop of n consecutive cycles clears it at the n-th edge exactly when n equals `STOP_CYC`; any shorter stop leaves it set.
- R7: Stop cycles separated by a cycle with `run_cmd`=1 do not add up toward `STOP_CYC`.
- R8: Asserting `rst` clears a latched fault, so `hs_off` is 0 once the logic reset hold of R1 has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| run_cmd | input | 1 | 1 = run commanded, 0 = stop commanded |
| in_lock | input | 1 | 1 = motor speed inside the lock window |
| stall_limit | input | LIMIT_W | Timeout in prescaled ticks |
| hs_off | output | 1 | 1 = high-side drivers disabled |
| logic_rst | output | 1 | Stretched reset for the control logic |

## Verification
The bench builds the block with `PRESCALE`=4, `STOP_CYC`=20 and `POR_CYC`=6, which turns millisecond-scale windows into a few dozen cycles. At that size every stall limit from 0 to 6 is swept with the rise of `hs_off` pinned to one exact edge, and every stop length from 1 to `STOP_CYC` is tried against a latched fault, so both the off-by-one edges of the timeout and the clear threshold are observed directly. Lock and stop interruptions one edge before expiry and the full reset hold are checked edge by edge.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  function automatic int cnt_bits(input int top);
    cnt_bits = (top < 2) ? 1 : $clog2(top + 1);
  endfunction
endpackage

// File: rtl/rsg_por.sv
module rsg_por #(
  parameter int POR_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  output logic logic_rst
);
  import rsg_pkg::*;
  localparam int CW = cnt_bits(POR_CYC);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(POR_CYC - 1)) hold_q <= 1'b0;
    end
  end

  assign logic_rst = hold_q;

  AST_POR_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    !hold_q |=> !hold_q); // R1
endmodule

// File: rtl/rsg_prescaler.sv
module rsg_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic clr,
  output logic tick
);
  import rsg_pkg::*;
  localparam int CW = cnt_bits(DIV);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = !clr;
    end else begin : g_div
      logic [CW-1:0] pcnt_q;
      always_ff @(posedge clk) begin
        if (clr || pcnt_q == CW'(DIV - 1)) pcnt_q <= '0;
        else                                pcnt_q <= pcnt_q + 1'b1;
      end
      assign tick = !clr && (pcnt_q == CW'(DIV - 1));

      AST_TICK_RESTARTS: assert property (@(posedge clk)
        clr |=> pcnt_q == '0); // R4
    end
  endgenerate
endmodule

// File: rtl/rsg_stall_timer.sv
module rsg_stall_timer #(
  parameter int LIMIT_W = 24
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               armed,
  input  logic               tick,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  logic [LIMIT_W-1:0] t_q;
  logic [LIMIT_W:0]   t_next;

  assign t_next = {1'b0, t_q} + 1'b1;
  assign expire = armed && tick && (t_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (clr || !armed)        t_q <= '0;
    else if (tick && !expire) t_q <= t_q + 1'b1;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (clr)
    !armed |=> t_q == '0); // R5
endmodule

// File: rtl/rsg_stop_qual.sv
module rsg_stop_qual #(
  parameter int STOP_CYC = 1000
) (
  input  logic clk,
  input  logic clr,
  input  logic run_cmd,
  output logic stop_done
);
  import rsg_pkg::*;
  localparam int CW = cnt_bits(STOP_CYC);

  logic [CW-1:0] scnt_q;

  always_ff @(posedge clk) begin
    if (clr || run_cmd)               scnt_q <= '0;
    else if (scnt_q != CW'(STOP_CYC)) scnt_q <= scnt_q + 1'b1;
  end

  assign stop_done = !run_cmd && (scnt_q == CW'(STOP_CYC - 1));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
    scnt_q <= CW'(STOP_CYC)); // R6
  AST_RUN_RESTARTS: assert property (@(posedge clk) disable iff (clr)
    run_cmd |=> scnt_q == '0); // R7
endmodule

// File: rtl/rotor_stall_guard.sv
module rotor_stall_guard #(
  parameter int LIMIT_W  = 24,
  parameter int PRESCALE = 1000,
  parameter int STOP_CYC = 250000,
  parameter int POR_CYC  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_cmd,
  input  logic               in_lock,
  input  logic [LIMIT_W-1:0] stall_limit,
  output logic               hs_off,
  output logic               logic_rst
);
  logic fault_q;
  logic armed;
  logic tick;
  logic expire;
  logic stop_done;

  rsg_por #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst(rst), .logic_rst(logic_rst)
  );

  assign armed = run_cmd && !in_lock && !fault_q;

  rsg_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .clr(logic_rst || !armed), .tick(tick)
  );

  rsg_stall_timer #(.LIMIT_W(LIMIT_W)) u_tmr (
    .clk(clk), .clr(logic_rst), .armed(armed), .tick(tick),
    .limit(stall_limit), .expire(expire)
  );

  rsg_stop_qual #(.STOP_CYC(STOP_CYC)) u_stop (
    .clk(clk), .clr(logic_rst), .run_cmd(run_cmd), .stop_done(stop_done)
  );

  always_ff @(posedge clk) begin
    if (logic_rst)      fault_q <= 1'b0;
    else if (stop_done) fault_q <= 1'b0;
    else if (expire)    fault_q <= 1'b1;
  end

  assign hs_off = logic_rst | fault_q;

  AST_FAULT_NEEDS_STALL: assert property (@(posedge clk) disable iff (logic_rst)
    $rose(fault_q) |-> $past(run_cmd) && !$past(in_lock)); // R3
  AST_CLEAR_NEEDS_STOP: assert property (@(posedge clk) disable iff (logic_rst)
    $fell(fault_q) |-> !$past(run_cmd)); // R6
  AST_RESET_HOLDS_OFF: assert property (@(posedge clk)
    logic_rst |-> hs_off); // R2
endmodule

// File: tb/rotor_stall_guard_tb.sv
module rotor_stall_guard_tb;
  localparam int LW = 24;
  localparam int P  = 4;
  localparam int SC = 20;
  localparam int PC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_cmd = 1'b0;
  logic in_lock = 1'b1;
  logic [LW-1:0] stall_limit = '0;
  logic hs_off, logic_rst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rotor_stall_guard #(.LIMIT_W(LW), .PRESCALE(P), .STOP_CYC(SC), .POR_CYC(PC)) u_dut (
    .clk(clk), .rst(rst), .run_cmd(run_cmd), .in_lock(in_lock),
    .stall_limit(stall_limit), .hs_off(hs_off), .logic_rst(logic_rst)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_fault();
    run_cmd = 1'b0;
    edges(SC + 1);
    in_lock = 1'b1;
  endtask

  task automatic latch_fault();
    clear_fault();
    stall_limit = 1;
    run_cmd = 1'b1;
    in_lock = 1'b0;
    edges(P);
  endtask

  initial begin
    edges(3);
    check(logic_rst, 1'b1, "R1 in reset");
    check(hs_off, 1'b1, "R2 in reset");
    rst = 1'b0;
    for (int k = 1; k <= PC; k++) begin
      edges(1);
      check(logic_rst, (k < PC), "R1 hold");
      check(hs_off, (k < PC), "R2 hold");
    end
    edges(5);
    check(logic_rst, 1'b0, "R1 stays low");

    // R3: sweep limits 0..6
    for (int lim = 0; lim <= 6; lim++) begin
      int e;
      clear_fault();
      e = (lim == 0) ? P : lim * P;
      stall_limit = LW'(lim);
      run_cmd = 1'b1;
      in_lock = 1'b0;
      edges(e - 1);
      check(hs_off, 1'b0, "R3 before expiry");
      edges(1);
      check(hs_off, 1'b1, "R3 at expiry");
    end

    // R4: lock one edge before expiry restarts the count
    clear_fault();
    stall_limit = 3;
    run_cmd = 1'b1;
    in_lock = 1'b0;
    edges(3 * P - 1);
    in_lock = 1'b1;
    edges(1);
    in_lock = 1'b0;
    edges(3 * P - 1);
    check(hs_off, 1'b0, "R4 restart before");
    edges(1);
    check(hs_off, 1'b1, "R4 restart at");

    // R5: brief stop restarts the count
    clear_fault();
    stall_limit = 2;
    in_lock = 1'b0;
    run_cmd = 1'b1;
    edges(2 * P - 1);
    run_cmd = 1'b0;
    edges(1);
    run_cmd = 1'b1;
    edges(2 * P - 1);
    check(hs_off, 1'b0, "R5 restart before");
    edges(1);
    check(hs_off, 1'b1, "R5 restart at");

    // R6: fault holds through lock activity
    in_lock = 1'b1;
    edges(3);
    check(hs_off, 1'b1, "R6 lock ignored");
    in_lock = 1'b0;
    edges(3);
    check(hs_off, 1'b1, "R6 unlock ignored");

    // R6: stop length sweep
    for (int n = 1; n <= SC; n++) begin
      latch_fault();
      run_cmd = 1'b0;
      in_lock = 1'b1;
      edges(n);
      check(hs_off, (n < SC), "R6 stop length");
      run_cmd = 1'b1;
      edges(1);
      check(hs_off, (n < SC), "R6 after resume");
    end

    // R7: two short stops do not accumulate
    latch_fault();
    in_lock = 1'b1;
    run_cmd = 1'b0;
    edges(SC - 1);
    run_cmd = 1'b1;
    edges(1);
    run_cmd = 1'b0;
    edges(SC - 1);
    check(hs_off, 1'b1, "R7 split stop");
    run_cmd = 1'b1;
    edges(1);
    check(hs_off, 1'b1, "R7 split stop resumed");

    // R8: reset clears fault
    latch_fault();
    run_cmd = 1'b0;
    in_lock = 1'b1;
    rst = 1'b1;
    edges(2);
    rst = 1'b0;
    edges(PC);
    check(logic_rst, 1'b0, "R8 hold over");
    check(hs_off, 1'b0, "R8 fault cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule